// File: doc/BRIEF.md
# Address Bit Mask Controller

This block sits between a processor core's address generation and the logic that uses the physical address: the cache lookup and the external bus. It forces address bit 20 to zero while an active-low mask request is in effect. This reproduces the wraparound at 1 Mbyte that older real-mode software expects. The request arrives asynchronously. It is synchronized, delayed by a fixed recognition latency, and then sampled once per bus cycle. As a result, the address bit never changes while a cycle is in flight.

A bus cycle opens on an address strobe, if no cycle is already open. The mask decision is captured at that strobe and held until the cycle completes with ready. For a prefetch, completion is the ready that carries the last-transfer flag, so every transfer split off by narrow bus sizing keeps the same mask. For any other cycle, completion is the first ready. Invalidation cycles always pass bit 20 through unchanged. When an I/O write completes, the recognized mask loads straight from the synchronizer output and skips the rest of the delay line. This lets a request that arrived shortly before the ready take effect for the very next cycle. A debug output reports the mask that currently applies.

Top module: `addr_mask_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after it is released, mask_eff is 0 and addr_out equals addr_in.
- R2: When mask_eff is 1, addr_out bit 20 is 0. Every other bit of addr_out always equals the same bit of addr_in.
- R3: Suppose mask_req_n is driven low before rising edge k and held, with no I/O write completing. The applied mask outside a cycle stays 0 through edge k+2 and becomes 1 after edge k+3, which is four edges later.
- R4: Release of the request (mask_req_n high) follows the same four-edge latency, taking the idle mask from 1 back to 0.
- R5: A cycle opened by addr_strobe while no cycle is open uses the recognized mask of that clock. It keeps that mask until the cycle completes, whatever the request does in between. The next cycle picks up the new state.
- R6: A cycle opened with cyc_prefetch high completes only on rdy together with xfer_last high. Any further addr_strobe pulses inside it are ignored, and the mask captured at its first strobe holds across all its transfers.
- R7: With cyc_inval high at the opening strobe, the cycle passes bit 20 unmasked for its whole length. With cyc_inval high while idle, bit 20 is also unmasked.
- R8: Suppose a cycle opened with cyc_iowr high completes with rdy at edge k+2, and mask_req_n has been low since before edge k. The new mask then applies from the clock right after edge k+2, one clock earlier than R3 gives.
- R9: A cycle opened with cyc_prefetch low completes on its first rdy, whatever xfer_last is. A rdy while no cycle is open has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mask_req_n | input | 1 | Asynchronous mask request, active low |
| addr_strobe | input | 1 | Start of a bus cycle, active high |
| cyc_prefetch | input | 1 | Cycle at the strobe is a prefetch |
| cyc_inval | input | 1 | Cycle or current lookup is a cache invalidation |
| cyc_iowr | input | 1 | Cycle at the strobe is an I/O write |
| xfer_last | input | 1 | Ready marks the final transfer of a prefetch |
| rdy | input | 1 | Transfer ready, active high |
| addr_in | input | ADDR_W | Physical address from the core |
| addr_out | output | ADDR_W | Address with bit 20 conditionally forced low |
| mask_eff | output | 1 | Mask currently applied (debug) |

## Verification
The address output is combinational from addr_in and the held state, so it is checked in the same clock the address is driven. The change in the recognized request shows up four rising edges after the request is first sampled, or three when an I/O write completes. A captured cycle mask shows up from the strobe clock until the clock after the completing ready. Inputs change at the falling edge and all outputs are sampled one nanosecond later, before the next rising edge. A bench reference model advances on the same rising edges, so each comparison falls in the clock where the result is due. Directed sequences count the edges explicitly at the exact boundary clocks named in R3, R5, R6 and R8.

// File: rtl/amc_pkg.sv
package amc_pkg;

  // Context captured when a bus cycle opens.
  typedef struct packed {
    logic pf;    // prefetch: ends on rdy with xfer_last
    logic io;    // I/O write: fast recognition on completion
    logic mask;  // bit-20 mask frozen for the cycle
  } cyc_ctx_t;

  // Mask a fresh lookup would use: recognized request, except on invalidation.
  function automatic logic lookup_mask(input logic recog, input logic inval);
    return recog & ~inval;
  endfunction

  // Completion of an open cycle.
  function automatic logic cycle_done(input logic open, input logic ready,
                                      input logic pf, input logic last);
    return open & ready & (~pf | last);
  endfunction

endpackage

// File: rtl/amc_req_pipe.sv
module amc_req_pipe #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LATENCY     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  input  logic fast_load,
  output logic sync_out,
  output logic chain_end,
  output logic recog
);
  localparam int unsigned CHAIN = LATENCY - 1;

  logic [CHAIN-1:0] chain;

  generate
    if (CHAIN == 1) begin : g_short
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= ~req_n;
      end
    end else begin : g_long
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN-2:0], ~req_n};
      end
    end
  endgenerate

  assign sync_out  = chain[SYNC_STAGES-1];
  assign chain_end = chain[CHAIN-1];

  always_ff @(posedge clk) begin
    if (rst)            recog <= 1'b0;
    else if (fast_load) recog <= sync_out;
    else                recog <= chain_end;
  end

  AST_PIPE_RESET: assert property (@(posedge clk) rst |=> !recog); // R1
  AST_FAST_ONLY_ON_IO: assert property (@(posedge clk) disable iff (rst)
    (recog != $past(chain_end)) |-> $past(fast_load)); // R8

endmodule

// File: rtl/amc_cycle_track.sv
module amc_cycle_track
  import amc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic rdy,
  input  logic xfer_last,
  input  logic kind_pf,
  input  logic kind_io,
  input  logic kind_inval,
  input  logic recog,
  output logic in_cyc,
  output logic cyc_start,
  output logic cyc_end,
  output logic io_done,
  output logic eff_mask
);
  cyc_ctx_t ctx;
  logic     fresh_mask;

  assign fresh_mask = lookup_mask(recog, kind_inval);
  assign cyc_start  = strobe & ~in_cyc;
  assign cyc_end    = cycle_done(in_cyc, rdy, ctx.pf, xfer_last);
  assign io_done    = cyc_end & ctx.io;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cyc <= 1'b0;
      ctx    <= '0;
    end else if (cyc_start) begin
      in_cyc   <= 1'b1;
      ctx.pf   <= kind_pf;
      ctx.io   <= kind_io;
      ctx.mask <= fresh_mask;
    end else if (cyc_end) begin
      in_cyc <= 1'b0;
    end
  end

  always_comb begin
    if (cyc_start)   eff_mask = fresh_mask;
    else if (in_cyc) eff_mask = ctx.mask;
    else             eff_mask = fresh_mask;
  end

  AST_HOLD_MASK: assert property (@(posedge clk) disable iff (rst)
    (in_cyc && !cyc_end) |=> (in_cyc && $stable(eff_mask))); // R5
  AST_PF_SPANS: assert property (@(posedge clk) disable iff (rst)
    (in_cyc && ctx.pf && !xfer_last) |=> in_cyc); // R6
  AST_PLAIN_ENDS: assert property (@(posedge clk) disable iff (rst)
    (in_cyc && !ctx.pf && rdy) |=> !in_cyc); // R9

endmodule

// File: rtl/amc_addr_apply.sv
module amc_addr_apply #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned MASK_BIT = 20
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              mask_on,
  output logic [ADDR_W-1:0] addr_out
);
  localparam logic [ADDR_W-1:0] BIT_SEL = ADDR_W'(1) << MASK_BIT;

  function automatic logic [ADDR_W-1:0] force_low(input logic [ADDR_W-1:0] a,
                                                  input logic en);
    return en ? (a & ~BIT_SEL) : a;
  endfunction

  assign addr_out = force_low(addr_in, mask_on);

endmodule

// File: rtl/addr_mask_ctrl.sv
module addr_mask_ctrl #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned MASK_BIT    = 20,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LATENCY     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_req_n,
  input  logic              addr_strobe,
  input  logic              cyc_prefetch,
  input  logic              cyc_inval,
  input  logic              cyc_iowr,
  input  logic              xfer_last,
  input  logic              rdy,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              mask_eff
);
  localparam logic [ADDR_W-1:0] KEEP = ~(ADDR_W'(1) << MASK_BIT);

  logic sync_out, chain_end, recog;
  logic in_cyc, cyc_start, cyc_end, io_done;

  amc_req_pipe #(.SYNC_STAGES(SYNC_STAGES), .LATENCY(LATENCY)) u_pipe (
    .clk(clk), .rst(rst), .req_n(mask_req_n), .fast_load(io_done),
    .sync_out(sync_out), .chain_end(chain_end), .recog(recog)
  );

  amc_cycle_track u_track (
    .clk(clk), .rst(rst), .strobe(addr_strobe), .rdy(rdy),
    .xfer_last(xfer_last), .kind_pf(cyc_prefetch), .kind_io(cyc_iowr),
    .kind_inval(cyc_inval), .recog(recog), .in_cyc(in_cyc),
    .cyc_start(cyc_start), .cyc_end(cyc_end), .io_done(io_done),
    .eff_mask(mask_eff)
  );

  amc_addr_apply #(.ADDR_W(ADDR_W), .MASK_BIT(MASK_BIT)) u_apply (
    .addr_in(addr_in), .mask_on(mask_eff), .addr_out(addr_out)
  );

  AST_BIT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (addr_out & KEEP) == (addr_in & KEEP)); // R2
  AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    mask_eff |-> !addr_out[MASK_BIT]); // R2
  AST_INVAL_PASS: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && cyc_inval) |-> (addr_out[MASK_BIT] == addr_in[MASK_BIT])); // R7

endmodule

// File: tb/addr_mask_ctrl_test.sv
module addr_mask_ctrl_test;
  logic        clk = 1'b0;
  logic        rst, mask_req_n, addr_strobe, cyc_prefetch, cyc_inval;
  logic        cyc_iowr, xfer_last, rdy, mask_eff;
  logic [31:0] addr_in, addr_out;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  addr_mask_ctrl uut (
    .clk(clk), .rst(rst), .mask_req_n(mask_req_n), .addr_strobe(addr_strobe),
    .cyc_prefetch(cyc_prefetch), .cyc_inval(cyc_inval), .cyc_iowr(cyc_iowr),
    .xfer_last(xfer_last), .rdy(rdy), .addr_in(addr_in),
    .addr_out(addr_out), .mask_eff(mask_eff)
  );

  // Reference model built from the requirements.
  logic [2:0] m_seen;  // [0] newest sampled request
  logic m_rec, m_open, m_held, m_pf, m_io;

  always @(posedge clk) begin
    if (rst) begin
      m_seen <= '0; m_rec <= 0; m_open <= 0; m_held <= 0; m_pf <= 0; m_io <= 0;
    end else begin
      logic fin;
      fin = m_open && rdy && (!m_pf || xfer_last);
      m_seen <= {m_seen[1:0], !mask_req_n};
      m_rec  <= (fin && m_io) ? m_seen[1] : m_seen[2];
      if (addr_strobe && !m_open) begin
        m_open <= 1; m_held <= m_rec && !cyc_inval;
        m_pf <= cyc_prefetch; m_io <= cyc_iowr;
      end else if (fin) m_open <= 0;
    end
  end

  function automatic logic want_mask();
    if (m_open && !(addr_strobe && !m_open)) return m_held;
    return m_rec && !cyc_inval;
  endfunction

  function automatic logic [31:0] want_addr(input logic [31:0] a, input logic m);
    return m ? (a & 32'hFFEF_FFFF) : a;
  endfunction

  task automatic lit(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic look(input string tag);
    #1;
    lit(tag, {31'd0, mask_eff}, {31'd0, want_mask()});
    lit({tag, "/R2"}, addr_out, want_addr(addr_in, want_mask()));
  endtask

  task automatic adv();
    @(negedge clk);
    addr_in = $urandom | 32'h0010_0000;
  endtask

  task automatic idle_n(input string tag, input int n);
    for (int i = 0; i < n; i++) begin look(tag); adv(); end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1207));
    rst = 1; mask_req_n = 1; addr_strobe = 0; cyc_prefetch = 0; cyc_inval = 0;
    cyc_iowr = 0; xfer_last = 0; rdy = 0; addr_in = 32'h0012_3456;
    adv();
    for (int i = 0; i < 3; i++) begin
      look("R1"); lit("R1", {31'd0, mask_eff}, 0); lit("R1", addr_out, addr_in); adv();
    end
    rst = 0;
    look("R1"); lit("R1 after release", addr_out, addr_in); adv();

    // R3: four-edge assertion latency
    mask_req_n = 0;
    for (int i = 0; i <= 4; i++) begin
      look("R3"); lit("R3", {31'd0, mask_eff}, (i == 4) ? 1 : 0);
      lit("R2", addr_out, (i == 4) ? (addr_in & 32'hFFEF_FFFF) : addr_in);
      adv();
    end
    // R4: same latency on release
    mask_req_n = 1;
    for (int i = 0; i <= 4; i++) begin
      look("R4"); lit("R4", {31'd0, mask_eff}, (i == 4) ? 0 : 1); adv();
    end

    // R5: request rises at the strobe clock; cycle stays unmasked
    addr_strobe = 1; mask_req_n = 0;
    look("R5"); lit("R5", {31'd0, mask_eff}, 0); adv();
    addr_strobe = 0;
    for (int i = 0; i < 6; i++) begin look("R5"); lit("R5 held", {31'd0, mask_eff}, 0); adv(); end
    rdy = 1; look("R5"); adv(); rdy = 0;
    look("R5"); lit("R5 next", {31'd0, mask_eff}, 1); adv();

    // R6: prefetch split into three transfers keeps its mask
    addr_strobe = 1; cyc_prefetch = 1;
    look("R6"); lit("R6", {31'd0, mask_eff}, 1); adv();
    addr_strobe = 0; mask_req_n = 1;
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < 3; i++) begin look("R6"); lit("R6 hold", {31'd0, mask_eff}, 1); adv(); end
      rdy = 1; xfer_last = (t == 2);
      look("R6"); lit("R6 rdy", {31'd0, mask_eff}, 1); adv();
      rdy = 0; xfer_last = 0;
      if (t < 2) begin
        addr_strobe = 1; look("R6"); lit("R6 restrobe", {31'd0, mask_eff}, 1); adv();
        addr_strobe = 0;
      end
    end
    cyc_prefetch = 0;
    look("R6"); lit("R6 done", {31'd0, mask_eff}, 0); adv();

    // R7: invalidation passes bit 20
    mask_req_n = 0; idle_n("R7", 6);
    addr_strobe = 1; cyc_inval = 1;
    look("R7"); lit("R7", addr_out, addr_in); adv();
    addr_strobe = 0;
    look("R7"); lit("R7", addr_out, addr_in); adv();
    rdy = 1; look("R7"); adv(); rdy = 0;
    look("R7"); lit("R7 idle", addr_out, addr_in); adv();
    cyc_inval = 0;
    look("R7"); lit("R7 off", {31'd0, mask_eff}, 1); adv();

    // R9: plain cycle ends on first rdy even without xfer_last
    addr_strobe = 1; look("R9"); adv(); addr_strobe = 0;
    mask_req_n = 1; idle_n("R9", 6);
    look("R9"); lit("R9 held", {31'd0, mask_eff}, 1); adv();
    rdy = 1; look("R9"); adv(); rdy = 0;
    look("R9"); lit("R9 ended", {31'd0, mask_eff}, 0); adv();
    rdy = 1; look("R9"); adv(); rdy = 0;
    look("R9"); lit("R9 stray rdy", {31'd0, mask_eff}, 0); adv();

    // R8: I/O write completion recognizes one clock early; data cycle does not
    for (int v = 0; v < 2; v++) begin
      addr_strobe = 1; cyc_iowr = (v == 0); look("R8"); adv();
      addr_strobe = 0; idle_n("R8", 2);
      mask_req_n = 0; look("R8"); adv();
      look("R8"); adv();
      rdy = 1; look("R8"); adv(); rdy = 0; cyc_iowr = 0;
      look("R8"); lit(v == 0 ? "R8 fast" : "R8 data R3", {31'd0, mask_eff}, v == 0 ? 1 : 0); adv();
      mask_req_n = 1; idle_n("R8", 6);
    end

    // Random mix against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(11) == 0) mask_req_n = ~mask_req_n;
      addr_strobe  = ($urandom_range(3) == 0);
      cyc_prefetch = $urandom_range(1);
      cyc_inval    = ($urandom_range(5) == 0);
      cyc_iowr     = ($urandom_range(2) == 0);
      rdy          = ($urandom_range(2) == 0);
      xfer_last    = $urandom_range(1);
      look("R5/R6/R7/R8/R9 random");
      adv();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule